// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine accepts a byte stream carrying end-of-frame and error side-band flags and spreads the bytes across a circular table of receive buffer descriptors held in a separate descriptor RAM. Each descriptor takes two 32-bit words. The first word is at `ring_base + 2*index` and holds status in bits [31:16] and length in bits [15:0]. The second word, at the next address, holds the buffer start address. Bytes are written one per cycle to a byte-wide data memory port at the buffer address plus the running count.

A buffer closes when it reaches `max_len` bytes, when a byte flagged end-of-frame arrives, or when a byte flagged error arrives. On close the engine writes back the first word with the byte count and updated status, then moves to the next descriptor. The next descriptor is the one at the table base if the closed descriptor had its wrap bit set. Software owns a descriptor while its empty bit is clear. The engine waits on such a descriptor, re-reading it until the bit is set. While it waits it consumes and discards the incoming bytes and reports each dropped frame once on `busy_err`.

Top module: `rx_ring_engine`

## Requirements
- R1: Each byte accepted while a descriptor with empty bit (status bit 15) set is open is written once to data memory at buffer address (second descriptor word) plus the number of bytes already stored in that buffer.
- R2: A buffer closes after the byte that brings its count to `max_len`, or after a byte with `in_eof` or `in_err` set. The length field [15:0] written back equals the number of bytes stored.
- R3: While the current descriptor's empty bit is 0, `in_ready` is high, bytes are discarded without any data memory write, and `busy_err` pulses for one cycle on the first discarded byte of each frame.
- R4: The engine does not move past a descriptor whose empty bit is 0. It re-reads that descriptor and starts storing into it once software sets the bit.
- R5: On write-back the empty bit is cleared, unless the continuous-mode bit (status bit 9) is set, in which case it stays set.
- R6: Write-back status sets last-in-frame (bit 11) when the buffer closed on `in_eof` or `in_err`, sets error (bit 0) when it closed on `in_err`, and keeps the wrap (13), interrupt-enable (12) and continuous-mode (9) bits as read.
- R7: After a descriptor with the wrap bit (status bit 13) is closed, the next descriptor read is at `ring_base`. Otherwise the next descriptor read is two words further.
- R8: `irq` is a one-cycle pulse in the cycle after the write-back of a descriptor whose interrupt-enable bit (status bit 12) is set, and only then.
- R9: Out of reset `in_ready`, `busy_err`, `irq` and both write strobes are low, and the first descriptor read is at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | DA_W | Descriptor RAM word address of descriptor 0 |
| max_len | input | 16 | Buffer capacity in bytes |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_eof | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Byte ends its frame with an error |
| in_ready | output | 1 | Byte taken this cycle when in_valid is high |
| dr_rd | output | 1 | Descriptor RAM read; data returns next cycle |
| dr_we | output | 1 | Descriptor RAM write |
| dr_addr | output | DA_W | Descriptor RAM word address |
| dr_wdata | output | 32 | Descriptor RAM write data |
| dr_rdata | input | 32 | Descriptor RAM read data |
| dm_we | output | 1 | Data memory byte write |
| dm_addr | output | AW | Data memory byte address |
| dm_wdata | output | 8 | Data memory byte |
| busy_err | output | 1 | Pulse: a frame is being dropped |
| irq | output | 1 | Pulse: descriptor written back with interrupt enabled |

## Verification
The assertions take for granted that `max_len` is at least one and that `max_len` and `ring_base` hold steady while the engine runs. They also assume the descriptor RAM returns read data exactly one cycle after `dr_rd`. The bench sets `ring_base` and `max_len` once, before reset is released. Its memory model registers every read. Software-side descriptor updates are made only while the engine is polling, so they never collide with a write-back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W   = 16;
  localparam int ST_E    = 15;
  localparam int ST_W    = 13;
  localparam int ST_I    = 12;
  localparam int ST_L    = 11;
  localparam int ST_CM   = 9;
  localparam int ST_ER   = 0;

  typedef enum logic [2:0] {
    S_RD0  = 3'd0,
    S_CHK  = 3'd1,
    S_RDP  = 3'd2,
    S_RECV = 3'd3,
    S_WB   = 3'd4
  } rxr_state_e;

  // Status word to write back on close.
  function automatic logic [15:0] close_status(input logic [15:0] st,
                                               input logic last,
                                               input logic err);
    logic [15:0] r;
    r = st;
    r[ST_E]  = st[ST_CM] ? st[ST_E] : 1'b0;
    r[ST_L]  = st[ST_L] | last;
    r[ST_ER] = st[ST_ER] | err;
    return r;
  endfunction

  // True when the byte being stored fills the buffer.
  function automatic logic fills(input logic [LEN_W-1:0] cnt,
                                 input logic [LEN_W-1:0] cap);
    return ({1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1}) >= {1'b0, cap};
  endfunction
endpackage

// File: rtl/rxr_drop_ctl.sv
module rxr_drop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic take,
  input  logic frame_end,
  output logic discard,
  output logic busy_pulse
);
  logic dropping_q;

  assign discard = stall | dropping_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dropping_q <= 1'b0;
      busy_pulse <= 1'b0;
    end else begin
      busy_pulse <= take && discard && !dropping_q;
      if (take && discard)
        dropping_q <= !frame_end;
    end
  end
endmodule

// File: rtl/rxr_cursor.sv
module rxr_cursor #(
  parameter int DA_W  = 10,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DA_W-1:0] base,
  input  logic            advance,
  input  logic            wrap,
  output logic [DA_W-1:0] addr_stat,
  output logic [DA_W-1:0] addr_ptr
);
  localparam int PAD = DA_W - IDX_W - 1;
  logic [IDX_W-1:0] idx_q;
  logic [DA_W-1:0]  off;

  assign off       = {{PAD{1'b0}}, idx_q, 1'b0};
  assign addr_stat = base + off;
  assign addr_ptr  = addr_stat + {{(DA_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= wrap ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int DA_W  = 10,
  parameter int IDX_W = 6,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DA_W-1:0]  ring_base,
  input  logic [15:0]      max_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  input  logic             in_err,
  output logic             in_ready,
  output logic             dr_rd,
  output logic             dr_we,
  output logic [DA_W-1:0]  dr_addr,
  output logic [31:0]      dr_wdata,
  input  logic [31:0]      dr_rdata,
  output logic             dm_we,
  output logic [AW-1:0]    dm_addr,
  output logic [7:0]       dm_wdata,
  output logic             busy_err,
  output logic             irq
);
  rxr_state_e       state_q;
  logic [15:0]      stat_q;
  logic [LEN_W-1:0] cnt_q;
  logic [AW-1:0]    ptr_q;
  logic             last_q, err_q, stall_q;

  logic [DA_W-1:0]  a_stat, a_ptr;
  logic             discard, take, store, close_now, wb_fire;
  logic             cm_cur, w_cur, ie_cur;
  wire              unused_rd = ^{dr_rdata[15:0], dr_rdata[31:AW]};

  assign cm_cur  = stat_q[ST_CM];
  assign w_cur   = stat_q[ST_W];
  assign ie_cur  = stat_q[ST_I];
  assign wb_fire = (state_q == S_WB);

  assign in_ready  = discard || (state_q == S_RECV);
  assign take      = in_valid && in_ready;
  assign store     = take && (state_q == S_RECV) && !discard;
  assign close_now = in_eof || in_err || fills(cnt_q, max_len);

  assign dm_we    = store;
  assign dm_addr  = ptr_q + cnt_q[AW-1:0];
  assign dm_wdata = in_data;

  always_comb begin
    dr_rd    = 1'b0;
    dr_we    = 1'b0;
    dr_addr  = a_stat;
    dr_wdata = {close_status(stat_q, last_q, err_q), cnt_q};
    case (state_q)
      S_RD0: dr_rd = 1'b1;
      S_CHK: if (dr_rdata[16+ST_E]) begin
               dr_rd   = 1'b1;
               dr_addr = a_ptr;
             end
      S_WB:  dr_we = 1'b1;
      default: ;
    endcase
  end

  rxr_cursor #(.DA_W(DA_W), .IDX_W(IDX_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .base(ring_base),
    .advance(wb_fire), .wrap(w_cur),
    .addr_stat(a_stat), .addr_ptr(a_ptr)
  );

  rxr_drop_ctl u_drop (
    .clk(clk), .rst_n(rst_n), .stall(stall_q), .take(take),
    .frame_end(in_eof || in_err), .discard(discard), .busy_pulse(busy_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_RD0;
      stat_q  <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      stall_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= wb_fire && ie_cur;
      case (state_q)
        S_RD0: state_q <= S_CHK;
        S_CHK: begin
          stat_q <= dr_rdata[31:16];
          if (dr_rdata[16+ST_E]) begin
            stall_q <= 1'b0;
            state_q <= S_RDP;
          end else begin
            stall_q <= 1'b1;
            state_q <= S_RD0;
          end
        end
        S_RDP: begin
          ptr_q   <= dr_rdata[AW-1:0];
          cnt_q   <= '0;
          state_q <= S_RECV;
        end
        S_RECV: if (store) begin
          cnt_q <= cnt_q + 1'b1;
          if (close_now) begin
            last_q  <= in_eof || in_err;
            err_q   <= in_err;
            state_q <= S_WB;
          end
        end
        S_WB: state_q <= S_RD0;
        default: state_q <= S_RD0;
      endcase
    end
  end
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
  parameter int DA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     max_len,
  input logic [DA_W-1:0] ring_base,
  input logic [15:0]     cnt_q,
  input logic            stall_q,
  input logic            cm_cur,
  input logic            w_cur,
  input logic            dm_we,
  input logic            dr_we,
  input logic            dr_rd,
  input logic [DA_W-1:0] dr_addr,
  input logic [31:0]     dr_wdata,
  input logic            busy_err,
  input logic            irq
);
  // R2: never store beyond buffer capacity
  p_store_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (cnt_q < max_len));
  // R3: a busy pulse follows a discarded byte, never a stored one
  p_busy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> !$past(dm_we));
  // R4: no storing while the descriptor is owned by software
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> !dm_we);
  // R5: empty bit cleared on write-back outside continuous mode
  p_e_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_we && !cm_cur) |-> !dr_wdata[31]);
  // R5: empty bit kept in continuous mode
  p_cm_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_we && cm_cur) |-> dr_wdata[31]);
  // R7: wrap returns to table base
  p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_we && w_cur) |=> (dr_rd && dr_addr == ring_base));
  // R8: interrupt only right after a write-back
  p_irq_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dr_we));
  // R1: one memory action per cycle
  p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dm_we, dr_we, dr_rd}));
endmodule

bind rx_ring_engine rxr_chk #(.DA_W(DA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .max_len(max_len), .ring_base(ring_base),
  .cnt_q(cnt_q), .stall_q(stall_q), .cm_cur(cm_cur), .w_cur(w_cur),
  .dm_we(dm_we), .dr_we(dr_we), .dr_rd(dr_rd), .dr_addr(dr_addr),
  .dr_wdata(dr_wdata), .busy_err(busy_err), .irq(irq)
);

// File: tb/rx_ring_engine_tb.sv
`timescale 1ns/100ps
module rx_ring_engine_tb;
  localparam int DA_W = 10;
  localparam int AW   = 12;
  localparam logic [DA_W-1:0] BASE = 10'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, dr_rd, dr_we, dm_we, busy_err, irq;
  logic [DA_W-1:0] dr_addr;
  logic [31:0] dr_wdata, dr_rdata;
  logic [AW-1:0] dm_addr;
  logic [7:0] dm_wdata;
  logic [15:0] max_len = 16'd8;

  logic tb_we = 1'b0;
  logic [DA_W-1:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] dram [1024];
  logic [7:0]  bmem [4096];

  int checks = 0, fails = 0, irq_n = 0, busy_n = 0;

  always #2.5 clk = ~clk;

  rx_ring_engine #(.DA_W(DA_W), .IDX_W(6), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .max_len(max_len),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
    .in_ready(in_ready), .dr_rd(dr_rd), .dr_we(dr_we), .dr_addr(dr_addr),
    .dr_wdata(dr_wdata), .dr_rdata(dr_rdata), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .busy_err(busy_err), .irq(irq)
  );

  initial begin
    for (int i = 0; i < 1024; i++) dram[i] = '0;
    for (int i = 0; i < 4096; i++) bmem[i] = '0;
  end

  always @(posedge clk) begin
    if (dr_rd) dr_rdata <= dram[dr_addr];
    if (dr_we) dram[dr_addr] <= dr_wdata;
    else if (tb_we) dram[tb_addr] <= tb_data;
    if (dm_we) bmem[dm_addr] <= dm_wdata;
    if (rst_n && irq) irq_n <= irq_n + 1;
    if (rst_n && busy_err) busy_n <= busy_n + 1;
  end

  // Frame table: length, error flag, re-arm descriptor 0 first,
  // expected cumulative irq and busy pulses after the frame.
  localparam int NF = 7;
  localparam int F_LEN   [NF] = '{5, 3, 8, 10, 2, 3, 1};
  localparam int F_ERR   [NF] = '{0, 1, 0, 0, 0, 0, 0};
  localparam int F_REARM [NF] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int X_IRQ   [NF] = '{1, 1, 2, 3, 3, 3, 3};
  localparam int X_BUSY  [NF] = '{0, 0, 0, 1, 1, 2, 3};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tb_write(input logic [DA_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic eof, input logic err);
    logic ok;
    in_valid = 1'b1; in_data = d; in_eof = eof; in_err = err;
    forever begin
      ok = in_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // descriptors: status in [31:16], pointer in next word
    tb_write(BASE + 0, 32'h9000_0000); tb_write(BASE + 1, 32'h0000_0000);
    tb_write(BASE + 2, 32'h8000_0000); tb_write(BASE + 3, 32'h0000_0100);
    tb_write(BASE + 4, 32'h9200_0000); tb_write(BASE + 5, 32'h0000_0200);
    tb_write(BASE + 6, 32'hB000_0000); tb_write(BASE + 7, 32'h0000_0300);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state, engine about to read descriptor 0
    check("R9 in_ready", {31'd0, in_ready}, 32'd0);
    check("R9 busy_err", {31'd0, busy_err}, 32'd0);
    check("R9 irq", {31'd0, irq}, 32'd0);
    check("R9 first read", {22'd0, dr_addr}, {22'd0, BASE});
    check("R9 no writes", {30'd0, dr_we, dm_we}, 32'd0);

    for (int f = 0; f < NF; f++) begin
      if (F_REARM[f] != 0) begin
        tb_write(BASE + 0, 32'h8000_0000);   // R4: software releases descriptor 0
        repeat (10) @(posedge clk);
        #1;
      end
      for (int k = 0; k < F_LEN[f]; k++) begin
        logic lastb;
        lastb = (k == F_LEN[f] - 1);
        send_byte({f[3:0], k[3:0]}, lastb && F_ERR[f] == 0, lastb && F_ERR[f] != 0);
      end
      repeat (20) @(posedge clk);
      #1;
      check($sformatf("R8 irq count frame %0d", f), irq_n, X_IRQ[f]);
      check($sformatf("R3 busy count frame %0d", f), busy_n, X_BUSY[f]);
    end

    // R2 R5 R6: write-back contents
    check("R6 desc0 after rearm", dram[BASE + 0], 32'h0800_0002);
    check("R6 desc1 error close", dram[BASE + 2], 32'h0801_0003);
    check("R5 desc2 continuous", dram[BASE + 4], 32'h9A00_0008);
    check("R2 desc3 full close", dram[BASE + 6], 32'h3000_0008);
    // R1 data placement
    check("R1 f4 byte0", {24'd0, bmem[12'h000]}, 32'h40);
    check("R1 f4 byte1", {24'd0, bmem[12'h001]}, 32'h41);
    check("R1 f0 byte4", {24'd0, bmem[12'h004]}, 32'h04);
    check("R1 f1 byte2", {24'd0, bmem[12'h102]}, 32'h12);
    check("R2 f2 byte7", {24'd0, bmem[12'h207]}, 32'h27);
    check("R2 f3 byte7", {24'd0, bmem[12'h307]}, 32'h37);
    check("R3 f3 tail dropped", {24'd0, bmem[12'h308]}, 32'h00);
    check("R4 desc1 untouched while owned", dram[BASE + 2], 32'h0801_0003);
    check("R3 no f5 data", {24'd0, bmem[12'h500]}, 32'h00);
    // R7: frame 4 landing at buffer 0 after desc3 shows the wrap

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule